// File: doc/BRIEF.md
# Compare-Match System Tick Timer

This peripheral keeps a 64-bit tick count that starts at reset and advances by one on every clock cycle for as long as the block is out of reset. Software cannot load or pause it. A single 32-bit compare channel is checked against the lower half of the count. When the two are equal and the channel is armed, a sticky match flag is raised. An active-high level interrupt is then driven for as long as both the flag and the arm bit are set.

Software reaches the block over a plain word-wide register port. A cycle with `bus_sel` high is one access. `bus_we` selects a write. Every access is acknowledged by `bus_rdy` one cycle later, and for a read the data in that cycle is the register value at the access cycle. The two count halves have no shared snapshot. To get a consistent 64-bit value, software reads upper, lower and upper again, and repeats the sequence if the two upper values differ.

A typical tick service routine reads the lower count, adds the wanted delay and writes the sum as the target. It then sets the arm bit. In the handler it clears the arm bit and writes one to the flag bit in a single store.

Top module: `tick_cmp_timer`

## Requirements
- R1: After reset the status word and the target register read 0, `irq` is 0, `bus_rdy` is 0, and the count equals the `RESET_COUNT` parameter (default 0).
- R2: The 64-bit count rises by exactly one every clock cycle out of reset. Writes to offsets 0x04 and 0x08 leave it unchanged.
- R3: A read at offset 0x04 returns bits 31:0 of the count and a read at 0x08 returns bits 63:32, each as the count stood in the cycle `bus_sel` was high. `bus_rdy` and the data follow one cycle after every access. An upper-half read that comes after a carry returns the new upper value.
- R4: The status word is at offset 0x00, with the match flag in bit 0 and the arm bit in bit 4; all other bits read 0. The 32-bit target register is at offset 0x0C.
- R5: If the arm bit is 1 in a cycle where count bits 31:0 equal the target, the flag is 1 from the next cycle on. `irq` is high exactly when the flag and the arm bit are both 1.
- R6: Writing the status word with bit 0 set clears the flag. Writing it with bit 0 clear leaves the flag as it was.
- R7: When a flag-clearing write and a new match fall in the same cycle, the flag ends up set.
- R8: While the arm bit is 0, no match is recorded, whatever the target holds.
- R9: The comparison is exact equality on 32 bits, so targets wrap modulo 2^32. A target 6 ticks ahead fires on time, and a target 0xFFFFFFFF ticks ahead does not fire early.
- R10: Reads of any other offset return 0, and writes to any other offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the count advances on every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rdy` follows a read |
| bus_rdy | output | 1 | Acknowledge, one cycle after `bus_sel` |
| irq | output | 1 | Level interrupt: flag AND arm bit |

## Verification
The bench lines up a flag-clearing store with the exact cycle the count reaches the target. A design that gives the clear priority would silently lose that tick. The count is started just below a 32-bit carry so that an upper, lower, upper read sequence straddles it. A design that latched the upper half on the lower read would then hide the carry, and a target programmed past the wrap would land at the wrong time. A target one tick behind the count, which is the farthest possible target, catches a magnitude comparator: such a design fires at once. A target six ticks ahead is timed cycle by cycle, which exposes an extra or a missing register stage on the flag path.

// File: rtl/tick_cmp_pkg.sv
package tick_cmp_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 2 * WORD_W;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_TARGET = 8'h0C;

    localparam int FLAG_BIT = 0;
    localparam int ARM_BIT  = 4;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_STATUS,
        RS_CNT_LO,
        RS_CNT_HI,
        RS_TARGET
    } reg_sel_e;

    typedef struct packed {
        logic              sel;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic              flag;
        logic              arm;
        logic [WORD_W-1:0] target;
    } chan_state_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e r;
        case (a)
            OFS_STATUS: r = RS_STATUS;
            OFS_CNT_LO: r = RS_CNT_LO;
            OFS_CNT_HI: r = RS_CNT_HI;
            OFS_TARGET: r = RS_TARGET;
            default:    r = RS_NONE;
        endcase
        return r;
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(input logic flag, input logic arm);
        logic [WORD_W-1:0] w;
        w           = '0;
        w[FLAG_BIT] = flag;
        w[ARM_BIT]  = arm;
        return w;
    endfunction

endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int            W    = 64,
    parameter logic [W-1:0]  INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) count <= INIT;
        else     count <= count + {{(W-1){1'b0}}, 1'b1};
    end

endmodule

// File: rtl/tick_cmp_channel.sv
module tick_cmp_channel
    import tick_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_status,
    input  logic              wr_target,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] cnt_lo,
    output chan_state_t       st
);

    logic hit;
    logic ack;

    // equality only: a target behind the count waits a full 2^32 lap
    always_comb begin
        hit = st.arm && (cnt_lo == st.target);
        ack = wr_status && wdata[FLAG_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (wr_target) st.target <= wdata;
            if (wr_status) st.arm    <= wdata[ARM_BIT];
            // a fresh hit outranks a simultaneous acknowledge
            st.flag <= hit | (st.flag & ~ack);
        end
    end

endmodule

// File: rtl/tick_bus_regs.sv
module tick_bus_regs
    import tick_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [CNT_W-1:0]  count,
    input  chan_state_t       st,
    output logic              wr_status,
    output logic              wr_target,
    output logic [WORD_W-1:0] rdata,
    output logic              rdy
);

    reg_sel_e          which;
    logic [WORD_W-1:0] rd_mux;
    logic              is_wr;
    logic              is_rd;

    always_comb begin
        which     = decode_addr(req.addr);
        is_wr     = req.sel && req.we;
        is_rd     = req.sel && !req.we;
        wr_status = is_wr && (which == RS_STATUS);
        wr_target = is_wr && (which == RS_TARGET);
        case (which)
            RS_STATUS: rd_mux = pack_status(st.flag, st.arm);
            RS_CNT_LO: rd_mux = count[WORD_W-1:0];
            RS_CNT_HI: rd_mux = count[CNT_W-1:WORD_W];
            RS_TARGET: rd_mux = st.target;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy   <= 1'b0;
            rdata <= '0;
        end else begin
            rdy   <= req.sel;
            rdata <= is_rd ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/tick_cmp_timer.sv
module tick_cmp_timer
    import tick_cmp_pkg::*;
#(
    parameter logic [63:0] RESET_COUNT = 64'd0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_rdy,
    output logic              irq
);

    bus_req_t          req;
    logic [CNT_W-1:0]  count;
    chan_state_t       st;
    logic              wr_status;
    logic              wr_target;
    logic              chan_flag;
    logic              chan_arm;
    logic [WORD_W-1:0] chan_target;

    always_comb begin
        req.sel   = bus_sel;
        req.we    = bus_we;
        req.addr  = bus_addr;
        req.wdata = bus_wdata;
    end

    tick_counter #(
        .W    (CNT_W),
        .INIT (RESET_COUNT)
    ) u_count (
        .clk   (clk),
        .rst   (rst),
        .count (count)
    );

    tick_bus_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .count     (count),
        .st        (st),
        .wr_status (wr_status),
        .wr_target (wr_target),
        .rdata     (bus_rdata),
        .rdy       (bus_rdy)
    );

    tick_cmp_channel u_chan (
        .clk       (clk),
        .rst       (rst),
        .wr_status (wr_status),
        .wr_target (wr_target),
        .wdata     (req.wdata),
        .cnt_lo    (count[WORD_W-1:0]),
        .st        (st)
    );

    assign chan_flag   = st.flag;
    assign chan_arm    = st.arm;
    assign chan_target = st.target;
    assign irq         = chan_flag & chan_arm;

endmodule

// File: rtl/tick_cmp_timer_chk.sv
module tick_cmp_timer_chk
    import tick_cmp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic              bus_rdy,
    input logic [CNT_W-1:0]  count,
    input logic              flag,
    input logic              arm,
    input logic [WORD_W-1:0] target
);

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> count == $past(count) + 64'd1);

    p_rdy_after_sel_r3: assert property (@(posedge clk) disable iff (rst)
        bus_sel |=> bus_rdy);

    p_rdy_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |=> !bus_rdy);

    p_flag_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(arm && (count[WORD_W-1:0] == target)));

    p_flag_clear_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(bus_sel && bus_we && (bus_addr == OFS_STATUS) && bus_wdata[FLAG_BIT]));

    p_match_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (arm && (count[WORD_W-1:0] == target)) |=> flag);

    p_target_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_we && (bus_addr == OFS_TARGET)) |=> $stable(target));

endmodule

bind tick_cmp_timer tick_cmp_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdy   (bus_rdy),
    .count     (count),
    .flag      (chan_flag),
    .arm       (chan_arm),
    .target    (chan_target)
);

// File: tb/tb_tick_cmp_timer.sv
`timescale 1ns/1ps
module tb_tick_cmp_timer;
    import tick_cmp_pkg::*;

    localparam logic [63:0] INIT = 64'h0000_0003_FFFF_F000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rdy;
    logic        irq;

    logic [63:0] mdl;
    logic [31:0] last_target;
    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    // expected tick count, straight from the counting requirement
    always @(posedge clk) mdl <= rst ? INIT : mdl + 64'd1;

    tick_cmp_timer #(.RESET_COUNT(INIT)) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_rdy   (bus_rdy),
        .irq       (irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [63:0] snap);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        snap = mdl;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_low(input logic [31:0] v);
        while (mdl[31:0] != v) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d; logic [63:0] s;
        do_reset();
        chk("R1", "irq after reset", {63'd0, irq}, 64'd0);
        chk("R1", "rdy after reset", {63'd0, bus_rdy}, 64'd0);
        rd(OFS_CNT_LO, d, s);
        chk("R1", "first low count", {32'd0, d}, {32'd0, INIT[31:0]});
        chk("R3", "rdy after read", {63'd0, bus_rdy}, 64'd1);
        rd(OFS_STATUS, d, s);
        chk("R1", "status after reset", {32'd0, d}, 64'd0);
        rd(OFS_TARGET, d, s);
        chk("R1", "target after reset", {32'd0, d}, 64'd0);
    endtask

    task automatic t_counter();
        logic [31:0] d, d2; logic [63:0] s, s2;
        rd(OFS_CNT_LO, d, s);
        chk("R3", "low word", {32'd0, d}, {32'd0, s[31:0]});
        rd(OFS_CNT_HI, d, s);
        chk("R3", "high word", {32'd0, d}, {32'd0, s[63:32]});
        wr(OFS_CNT_LO, 32'h0);
        wr(OFS_CNT_HI, 32'h0);
        rd(OFS_CNT_LO, d, s);
        chk("R2", "low after write attempt", {32'd0, d}, {32'd0, s[31:0]});
        rd(OFS_CNT_HI, d, s);
        chk("R2", "high after write attempt", {32'd0, d}, {32'd0, s[63:32]});
        rd(OFS_CNT_LO, d, s);
        rd(OFS_CNT_LO, d2, s2);
        chk("R2", "back-to-back step", {32'd0, d2 - d}, 64'd1);
    endtask

    task automatic t_match_near();
        logic [31:0] d; logic [63:0] s;
        logic [63:0] c, seen;
        c = mdl;
        seen = '0;
        wr(OFS_TARGET, c[31:0] + 32'd6);
        wr(OFS_STATUS, 32'h10);
        for (int i = 0; i < 50; i++) begin
            if (irq) begin seen = mdl; break; end
            @(negedge clk);
        end
        chk("R9", "irq cycle, target 6 ahead", seen, c + 64'd7);
        rd(OFS_STATUS, d, s);
        chk("R5", "status after match", {32'd0, d}, 64'h11);
    endtask

    task automatic t_flag_ack();
        logic [31:0] d; logic [63:0] s;
        wr(OFS_STATUS, 32'h10);
        rd(OFS_STATUS, d, s);
        chk("R6", "zero in bit0 keeps flag", {32'd0, d}, 64'h11);
        wr(OFS_STATUS, 32'h00);
        chk("R5", "irq with arm cleared", {63'd0, irq}, 64'd0);
        rd(OFS_STATUS, d, s);
        chk("R5", "flag held while disarmed", {32'd0, d}, 64'h01);
        wr(OFS_STATUS, 32'h10);
        chk("R5", "irq back on rearm", {63'd0, irq}, 64'd1);
        wr(OFS_STATUS, 32'h11);
        chk("R6", "irq after ack", {63'd0, irq}, 64'd0);
        rd(OFS_STATUS, d, s);
        chk("R6", "status after ack", {32'd0, d}, 64'h10);
    endtask

    task automatic t_clear_race();
        logic [31:0] d, tgt; logic [63:0] s;
        tgt = mdl[31:0] + 32'd10;
        wr(OFS_TARGET, tgt);
        wait_low(tgt);
        wr(OFS_STATUS, 32'h11);
        rd(OFS_STATUS, d, s);
        chk("R7", "ack in match cycle", {32'd0, d}, 64'h11);
        chk("R7", "irq after race", {63'd0, irq}, 64'd1);
    endtask

    task automatic t_oneshot();
        logic [31:0] d; logic [63:0] s;
        logic any;
        any = 1'b0;
        wr(OFS_STATUS, 32'h01);
        rd(OFS_STATUS, d, s);
        chk("R8", "disarm and ack", {32'd0, d}, 64'd0);
        wr(OFS_TARGET, mdl[31:0] + 32'd8);
        repeat (30) begin @(negedge clk); any = any | irq; end
        chk("R8", "irq while disarmed", {63'd0, any}, 64'd0);
        rd(OFS_STATUS, d, s);
        chk("R8", "no flag while disarmed", {32'd0, d}, 64'd0);
    endtask

    task automatic t_far_target();
        logic any;
        any = 1'b0;
        last_target = mdl[31:0] - 32'd1;
        wr(OFS_TARGET, last_target);
        wr(OFS_STATUS, 32'h10);
        repeat (2000) begin @(negedge clk); any = any | irq; end
        chk("R9", "target 0xFFFFFFFF ahead", {63'd0, any}, 64'd0);
        wr(OFS_STATUS, 32'h01);
    endtask

    task automatic t_undefined();
        logic [31:0] d; logic [63:0] s;
        rd(8'h10, d, s);
        chk("R10", "read 0x10", {32'd0, d}, 64'd0);
        rd(8'h1C, d, s);
        chk("R10", "read 0x1C", {32'd0, d}, 64'd0);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h0D, 32'hFFFF_FFFF);
        rd(OFS_STATUS, d, s);
        chk("R10", "status after stray writes", {32'd0, d}, 64'd0);
        rd(OFS_TARGET, d, s);
        chk("R10", "target after stray writes", {32'd0, d}, {32'd0, last_target});
        chk("R4", "target read back", {32'd0, d}, {32'd0, last_target});
    endtask

    task automatic t_wrap_carry();
        logic [31:0] h1, lo, h2; logic [63:0] s;
        logic [63:0] seen;
        seen = '0;
        do_reset();
        wr(OFS_TARGET, 32'h0000_0020);
        wr(OFS_STATUS, 32'h10);
        wait_low(32'hFFFF_FFFE);
        rd(OFS_CNT_HI, h1, s);
        rd(OFS_CNT_LO, lo, s);
        rd(OFS_CNT_HI, h2, s);
        chk("R3", "first high before carry", {32'd0, h1}, 64'd3);
        chk("R3", "low at carry", {32'd0, lo}, 64'hFFFF_FFFF);
        chk("R3", "second high after carry", {32'd0, h2}, 64'd4);
        for (int i = 0; i < 200; i++) begin
            if (irq) begin seen = mdl; break; end
            @(negedge clk);
        end
        chk("R9", "irq on wrapped target", seen, 64'h0000_0004_0000_0021);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_counter();
        t_match_near();
        t_flag_ack();
        t_clear_race();
        t_oneshot();
        t_far_target();
        t_undefined();
        t_wrap_carry();
        finish_run();
    end

endmodule